// File: doc/BRIEF.md
# Sign-Magnitude Accumulator with Overflow Bits

This block is a single accumulator register for a sign/magnitude datapath. Each operand is a 36-bit word: a sign bit at the top and a 35-bit magnitude below it. The accumulator keeps a sign and a 35-bit magnitude. Between them sit two extra guard bits, Q (upper) and P (lower), which catch carries out of the magnitude. One operation is issued per clock through a small opcode. The result appears on the accumulator output after the next rising edge.

The operations are load, arithmetic add and subtract, and a logical add. Add and subtract follow sign/magnitude rules: equal signs add the magnitudes; unequal signs subtract the smaller from the larger. The logical add treats P and the magnitude as one unsigned 36-bit field and feeds the carry out of P back into the least significant bit. It clears the sign and Q. A sticky overflow flag records any arithmetic carry into P. A test-and-clear input resets the flag.

Top module: `smag_accum`

## Requirements
- R1: While rst_ni is low, and after it is released, acc_o is all zeros and ovf_o is 0.
- R2: Opcode 1 (load) sets the accumulator sign to word_i[35] and the magnitude to word_i[34:0], and clears Q and P. Layout of acc_o: bit 37 = sign, bit 36 = Q, bit 35 = P, bits 34:0 = magnitude.
- R3: Opcode 2 (add) with operand sign equal to the accumulator sign adds the operand magnitude to the 37-bit Q:P:magnitude field, modulo 2^37, and keeps the sign.
- R4: An add whose signs differ subtracts the smaller of the Q:P:magnitude field and the operand magnitude from the larger. The result takes the sign of the larger. On a tie the accumulator sign is kept, so a negative zero is possible.
- R5: Opcode 3 (subtract) behaves as an add of the operand with word_i[35] inverted.
- R6: Opcode 4 (logical add) adds all 36 bits of word_i, as an unsigned number, to the P:magnitude field. A carry out of P is added back into bit 0. The sign and Q are cleared.
- R7: ovf_o is set after any add or subtract with equal effective signs whose magnitude sum reaches 2^35. It then stays set.
- R8: ovf_clr_i high for one cycle clears ovf_o at the next edge, unless an overflow is set in the same cycle; setting wins.
- R9: Opcodes 0, 5, 6 and 7 leave acc_o unchanged. Load, logical add and those opcodes never set ovf_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation select |
| word_i | input | 36 | Operand word, sign in bit 35 |
| ovf_clr_i | input | 1 | Clear the sticky overflow flag |
| acc_o | output | 38 | Sign, Q, P and magnitude |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that op_i, word_i and ovf_clr_i are known, stable values at every rising edge once reset is released. Their checks of the previous cycle's operand depend on this. The bench drives all inputs on the falling edge from a single task, so each value is settled a half period before it is sampled. Random stimulus covers all eight opcode values, including the unused ones. It biases magnitudes towards full scale and towards equal values so that carries, ties and wraps occur often.

// File: rtl/smag_pkg.sv
package smag_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 3'd0,
    OP_LOAD = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_LADD = 3'd4
  } op_e;
endpackage

// File: rtl/smag_mag_unit.sv
// Sign/magnitude add of an operand magnitude into the Q:P:mag field.
module smag_mag_unit #(
  parameter int unsigned MAG_W = 35,
  localparam int unsigned FIELD_W = MAG_W + 2
) (
  input  logic               acc_sign_i,
  input  logic [FIELD_W-1:0] acc_field_i,
  input  logic               opd_sign_i,
  input  logic [MAG_W-1:0]   opd_mag_i,
  output logic               res_sign_o,
  output logic [FIELD_W-1:0] res_field_o,
  output logic               carry_p_o
);
  logic               same_sign;
  logic [MAG_W:0]     low_sum;
  logic [FIELD_W-1:0] opd_ext;
  logic [FIELD_W-1:0] sum;
  logic [FIELD_W-1:0] diff_acc;
  logic [FIELD_W-1:0] diff_opd;
  logic               acc_ge;

  assign same_sign = (acc_sign_i == opd_sign_i);
  assign opd_ext   = {2'b00, opd_mag_i};
  assign low_sum   = {1'b0, acc_field_i[MAG_W-1:0]} + {1'b0, opd_mag_i};
  assign sum       = acc_field_i + opd_ext;
  assign diff_acc  = acc_field_i - opd_ext;
  assign diff_opd  = opd_ext - acc_field_i;
  assign acc_ge    = (acc_field_i >= opd_ext);

  always_comb begin
    carry_p_o = 1'b0;
    if (same_sign) begin
      res_sign_o  = acc_sign_i;
      res_field_o = sum;
      carry_p_o   = low_sum[MAG_W];
    end else if (acc_ge) begin
      res_sign_o  = acc_sign_i;   // ties keep accumulator sign
      res_field_o = diff_acc;
    end else begin
      res_sign_o  = opd_sign_i;
      res_field_o = diff_opd;
    end
  end
endmodule

// File: rtl/smag_eac_adder.sv
// Unsigned add with end-around carry; a single wrap suffices.
module smag_eac_adder #(
  parameter int unsigned W = 36
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] raw;

  assign raw   = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
endmodule

// File: rtl/smag_sticky_flag.sv
module smag_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/smag_accum.sv
module smag_accum
  import smag_pkg::*;
#(
  parameter int unsigned MAG_W = 35,
  localparam int unsigned WORD_W  = MAG_W + 1,
  localparam int unsigned FIELD_W = MAG_W + 2,
  localparam int unsigned ACC_W   = MAG_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              ovf_clr_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              ovf_o
);
  logic               sign_q, sign_d;
  logic [FIELD_W-1:0] field_q, field_d;

  op_e                op;
  logic               opd_sign;
  logic               arith_sign;
  logic [FIELD_W-1:0] arith_field;
  logic               carry_p;
  logic [WORD_W-1:0]  logic_sum;
  logic               is_arith;

  assign op       = op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);
  assign opd_sign = word_i[MAG_W] ^ (op == OP_SUB);

  smag_mag_unit #(.MAG_W(MAG_W)) u_mag (
    .acc_sign_i (sign_q),
    .acc_field_i(field_q),
    .opd_sign_i (opd_sign),
    .opd_mag_i  (word_i[MAG_W-1:0]),
    .res_sign_o (arith_sign),
    .res_field_o(arith_field),
    .carry_p_o  (carry_p)
  );

  // P and magnitude form one unsigned field, same width as a word
  smag_eac_adder #(.W(WORD_W)) u_eac (
    .a_i  (field_q[WORD_W-1:0]),
    .b_i  (word_i),
    .sum_o(logic_sum)
  );

  always_comb begin
    sign_d  = sign_q;
    field_d = field_q;
    unique case (op)
      OP_LOAD: begin
        sign_d  = word_i[MAG_W];
        field_d = {2'b00, word_i[MAG_W-1:0]};
      end
      OP_ADD, OP_SUB: begin
        sign_d  = arith_sign;
        field_d = arith_field;
      end
      OP_LADD: begin
        sign_d  = 1'b0;
        field_d = {1'b0, logic_sum};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sign_q  <= 1'b0;
      field_q <= '0;
    end else begin
      sign_q  <= sign_d;
      field_q <= field_d;
    end
  end

  smag_sticky_flag u_ovf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (is_arith & carry_p),
    .clr_i (ovf_clr_i),
    .flag_o(ovf_o)
  );

  assign acc_o = {sign_q, field_q};
endmodule

// File: rtl/smag_accum_chk.sv
module smag_accum_chk #(
  parameter int unsigned MAG_W = 35
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2:0]         op_i,
  input logic [MAG_W:0]     word_i,
  input logic               ovf_clr_i,
  input logic [MAG_W+2:0]   acc_o,
  input logic               ovf_o
);
  localparam logic [2:0] C_NOP = 3'd0, C_LOAD = 3'd1, C_ADD = 3'd2,
                         C_SUB = 3'd3, C_LADD = 3'd4;

  logic arith_op;
  assign arith_op = (op_i == C_ADD) || (op_i == C_SUB);

  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (acc_o == '0 && !ovf_o);
    end
  end

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == C_LOAD |=> acc_o == {$past(word_i[MAG_W]), 2'b00, $past(word_i[MAG_W-1:0])});

  a_r6_logic_clears_sign_q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == C_LADD |=> acc_o[MAG_W+2:MAG_W+1] == 2'b00);

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !ovf_clr_i |=> ovf_o);

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_clr_i && !arith_op |=> !ovf_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == C_NOP || op_i > C_LADD) |=> $stable(acc_o));

  a_r9_no_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_o && !arith_op |=> !ovf_o);
endmodule

bind smag_accum smag_accum_chk #(.MAG_W(MAG_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_i     (op_i),
  .word_i   (word_i),
  .ovf_clr_i(ovf_clr_i),
  .acc_o    (acc_o),
  .ovf_o    (ovf_o)
);

// File: tb/smag_accum_tb_top.sv
`timescale 1ns/1ps
module smag_accum_tb_top;
  localparam longint unsigned MAG_MOD   = 64'd1 << 35;
  localparam longint unsigned WORD_MOD  = 64'd1 << 36;
  localparam longint unsigned FIELD_MOD = 64'd1 << 37;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [35:0] word = '0;
  logic        clr = 1'b0;
  logic [37:0] acc;
  logic        ovf;

  int checks = 0;
  int errors = 0;

  bit              m_sign = 1'b0;
  longint unsigned m_field = 0;
  bit              m_ovf = 1'b0;

  always #2.5 clk = ~clk;

  smag_accum dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .word_i(word),
    .ovf_clr_i(clr), .acc_o(acc), .ovf_o(ovf)
  );

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd1: return "R2";
      3'd2: return "R3/R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic compare(input string tag);
    logic [37:0] exp_acc;
    exp_acc = {m_sign, m_field[36:0]};
    checks++;
    if (acc !== exp_acc) begin
      errors++;
      $display("FAIL %s acc: actual %h expected %h", tag, acc, exp_acc);
    end
    checks++;
    if (ovf !== m_ovf) begin
      errors++;
      $display("FAIL %s/R7/R8 ovf: actual %b expected %b", tag, ovf, m_ovf);
    end
  endtask

  task automatic model_step(input logic [2:0] o, input logic [35:0] w, input logic c);
    longint unsigned om, t;
    bit os, set;
    om  = longint'(w[34:0]);
    set = 1'b0;
    case (o)
      3'd1: begin m_sign = w[35]; m_field = om; end
      3'd2, 3'd3: begin
        os = w[35] ^ (o == 3'd3);
        if (os == m_sign) begin
          if ((m_field % MAG_MOD) + om >= MAG_MOD) set = 1'b1;
          m_field = (m_field + om) % FIELD_MOD;
        end else if (m_field >= om) begin
          m_field = m_field - om;
        end else begin
          m_field = om - m_field;
          m_sign  = os;
        end
      end
      3'd4: begin
        t = (m_field % WORD_MOD) + longint'(w);
        if (t >= WORD_MOD) t = t - WORD_MOD + 1;
        m_field = t;
        m_sign  = 1'b0;
      end
      default: ;
    endcase
    if (set)    m_ovf = 1'b1;
    else if (c) m_ovf = 1'b0;
  endtask

  task automatic apply(input logic [2:0] o, input logic [35:0] w, input logic c, input string tag);
    op = o; word = w; clr = c;
    model_step(o, w, c);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    apply(3'd1, {1'b0, 35'd5}, 1'b0, "R2");
    apply(3'd2, {1'b0, 35'd3}, 1'b0, "R3");            // +8
    apply(3'd2, {1'b1, 35'd10}, 1'b0, "R4");           // -2
    apply(3'd3, {1'b1, 35'd2}, 1'b0, "R4/R5");         // negative zero
    apply(3'd0, {1'b0, 35'd77}, 1'b0, "R9");
    apply(3'd6, {1'b1, 35'd1}, 1'b0, "R9");
    apply(3'd1, {1'b1, {35{1'b1}}}, 1'b0, "R2");
    apply(3'd3, {1'b0, 35'd1}, 1'b0, "R5/R7");         // carry into P, ovf
    apply(3'd1, {1'b0, 35'd9}, 1'b0, "R7");            // flag stays
    apply(3'd4, 36'd1, 1'b0, "R9");                    // logical add sets nothing
    apply(3'd0, '0, 1'b1, "R8");
    apply(3'd1, {1'b0, {35{1'b1}}}, 1'b0, "R2");
    apply(3'd2, {1'b0, {35{1'b1}}}, 1'b1, "R8");       // set beats clear
    apply(3'd2, {1'b0, {35{1'b1}}}, 1'b0, "R3");       // reaches Q
    apply(3'd2, {1'b0, {35{1'b1}}}, 1'b0, "R3");
    apply(3'd2, {1'b0, {35{1'b1}}}, 1'b0, "R3");       // wraps past Q
    apply(3'd4, 36'd0, 1'b1, "R6");                    // clears sign and Q
    apply(3'd1, {1'b0, {35{1'b1}}}, 1'b0, "R2");
    apply(3'd4, 36'h8_0000_0001, 1'b0, "R6");          // end-around -> 1
    apply(3'd1, {1'b1, 35'd4}, 1'b0, "R2");
    apply(3'd2, {1'b0, 35'd4}, 1'b0, "R4");            // tie keeps negative

    for (int i = 0; i < 4000; i++) begin
      logic [2:0]  o;
      logic [35:0] w;
      logic        c;
      o = 3'($urandom_range(0, 7));
      w = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
      case ($urandom_range(0, 3))
        0: w[34:0] = {35{1'b1}} - 35'($urandom_range(0, 3));
        1: w[34:0] = 35'(m_field);
        default: ;
      endcase
      c = ($urandom_range(0, 7) == 0);
      apply(o, w, c, tag_of(o));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule